// File: doc/BRIEF.md
# Protocol Flit Multiplexer for a Shared Link

This block feeds one link transmit port from three flit sources: an I/O channel, a coherent-cache channel and a memory channel. Each source offers flits over a valid/ready handshake. In every cycle the block picks at most one flit and sends it out with a 2-bit protocol tag. The output port also uses valid/ready backpressure. The choice can change on any flit boundary, so the three protocols interleave on the same lanes.

After link training, a mode input marked valid tells the block which mode the link runs in. In fallback mode the link is plain PCIe-compatible, and only the mandatory I/O channel is served. In full mode all three channels are live. Cache and memory flits have priority over I/O flits. When both coherency channels have a flit in the same cycle, they take turns. I/O flits fill the slots the coherency channels leave free. An optional starvation limit forces one I/O flit through after a run of cycles in which I/O was kept waiting.

Top module: `proto_flit_mux`

## Requirements
- R1: After reset, until a cycle in which `mode_valid` is high has been clocked in, `out_valid` and all three channel readies stay low.
- R2: The mode is captured on the first clock edge at which `mode_valid` is high. Later changes of `mode_cxl` or `mode_valid` have no effect until the next reset.
- R3: In fallback mode (`mode_cxl` captured as 0), `cache_ready` and `mem_ready` stay low and only I/O flits are sent.
- R4: The I/O channel can be granted in both modes.
- R5: In full mode, when cache or memory has a valid flit, an I/O flit is sent only under the starvation override of R7 or the stall hold of R10.
- R6: When cache and memory are both valid with no hold or override, the grant goes to the channel that was not granted most recently among the two. Memory counts as most recent after reset.
- R7: When `starve_limit` is nonzero, the block counts consecutive cycles in which `io_valid` was high and `io_ready` low. Once the count reaches `starve_limit` and `io_valid` is high, an I/O flit is selected.
- R8: A `starve_limit` of zero disables the override, so I/O can wait indefinitely behind coherency traffic.
- R9: `out_tag` is 00 for I/O, 01 for cache and 10 for memory. `out_data` equals the data of the tagged channel.
- R10: While `out_valid` is high and `out_ready` low, the next cycle keeps `out_valid` high with the same `out_tag` and `out_data`.
- R11: At most one channel ready is high, and only in a cycle where both `out_ready` and `out_valid` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_valid | input | 1 | Link mode has been settled by training |
| mode_cxl | input | 1 | 1 = full three-protocol mode, 0 = I/O-only fallback |
| starve_limit | input | STARVE_W | I/O starvation limit in cycles, 0 disables |
| io_valid | input | 1 | I/O channel has a flit |
| io_data | input | FLIT_W | I/O flit payload |
| io_ready | output | 1 | I/O flit accepted this cycle |
| cache_valid | input | 1 | Cache channel has a flit |
| cache_data | input | FLIT_W | Cache flit payload |
| cache_ready | output | 1 | Cache flit accepted this cycle |
| mem_valid | input | 1 | Memory channel has a flit |
| mem_data | input | FLIT_W | Memory flit payload |
| mem_ready | output | 1 | Memory flit accepted this cycle |
| out_valid | output | 1 | Link port has a flit |
| out_data | output | FLIT_W | Selected flit payload |
| out_tag | output | 2 | Protocol tag of the selected flit |
| out_ready | input | 1 | Link accepts the flit |

## Verification
The starvation override and the coherency priority can both apply in the same cycle. So can the output stall hold and a new higher-priority request. The bench builds the first case by keeping the cache and I/O channels valid under a small limit. It then checks that the I/O flit appears exactly `starve_limit` cycles after I/O started waiting. The second case comes from dropping `out_ready` while I/O is offered and raising a cache request during the stall; the tag must stay on I/O until the transfer completes. Random traffic with random backpressure is compared every cycle against a bench model of the requirements.

// File: rtl/flitmux_pkg.sv
// Shared types of the protocol flit multiplexer.
package flitmux_pkg;
    typedef enum logic [1:0] {
        TAG_IO    = 2'b00,
        TAG_CACHE = 2'b01,
        TAG_MEM   = 2'b10
    } proto_tag_e;
endpackage

// File: rtl/flitmux_mode_gate.sv
// Captures the link mode once, on the first cycle mode_valid is seen.
// Assumes the mode source is stable when it raises mode_valid.
module flitmux_mode_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_valid,
    input  logic mode_cxl,
    output logic locked,
    output logic cxl_en
);
    // Latch the mode on first valid; ignore everything afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            cxl_en <= 1'b0;
        end else if (!locked && mode_valid) begin
            locked <= 1'b1;
            cxl_en <= mode_cxl;
        end
    end
endmodule

// File: rtl/flitmux_starve_ctr.sv
// Counts consecutive cycles the I/O channel waits with a flit.
// Raises force_io once the count reaches a nonzero limit.
module flitmux_starve_ctr #(
    parameter int STARVE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_valid,
    input  logic                io_taken,
    input  logic [STARVE_W-1:0] limit,
    output logic [STARVE_W-1:0] count,
    output logic                force_io
);
    localparam logic [STARVE_W-1:0] CNT_MAX = '1;

    // Run length of unserved I/O cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (!io_valid || io_taken) count <= '0;
        else if (count != CNT_MAX)     count <= count + 1'b1;
    end

    // Override request when the wait has reached the limit.
    always_comb force_io = (limit != '0) && (count >= limit) && io_valid;
endmodule

// File: rtl/flitmux_arbiter.sv
// Picks one channel per cycle: hold on stall, starvation override,
// coherency classes (alternating), then I/O. Assumes sources hold
// valid until accepted.
module flitmux_arbiter
    import flitmux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locked,
    input  logic       cxl_en,
    input  logic       io_v,
    input  logic       cache_v,
    input  logic       mem_v,
    input  logic       force_io,
    input  logic       out_ready,
    output proto_tag_e sel,
    output logic       any,
    output logic       hold
);
    logic       prefer_mem;
    proto_tag_e hold_sel;
    logic       c_ok, m_ok;

    // Coherency channels only count in full mode.
    always_comb begin
        c_ok = cxl_en && cache_v;
        m_ok = cxl_en && mem_v;
    end

    // Selection by priority order.
    always_comb begin
        any = locked && (hold || io_v || c_ok || m_ok);
        if (hold)              sel = hold_sel;
        else if (force_io)     sel = TAG_IO;
        else if (c_ok && m_ok) sel = prefer_mem ? TAG_MEM : TAG_CACHE;
        else if (c_ok)         sel = TAG_CACHE;
        else if (m_ok)         sel = TAG_MEM;
        else                   sel = TAG_IO;
    end

    // Remember a stalled choice and the coherency turn.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold       <= 1'b0;
            hold_sel   <= TAG_IO;
            prefer_mem <= 1'b0;
        end else begin
            hold     <= any && !out_ready;
            hold_sel <= sel;
            if (any && out_ready && sel == TAG_CACHE) prefer_mem <= 1'b1;
            if (any && out_ready && sel == TAG_MEM)   prefer_mem <= 1'b0;
        end
    end
endmodule

// File: rtl/proto_flit_mux.sv
// Top: three flit sources onto one tagged link port with mode gating,
// class priority, coherency round-robin and I/O starvation override.
module proto_flit_mux
    import flitmux_pkg::*;
#(
    parameter int FLIT_W   = 32,
    parameter int STARVE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_valid,
    input  logic                mode_cxl,
    input  logic [STARVE_W-1:0] starve_limit,
    input  logic                io_valid,
    input  logic [FLIT_W-1:0]   io_data,
    output logic                io_ready,
    input  logic                cache_valid,
    input  logic [FLIT_W-1:0]   cache_data,
    output logic                cache_ready,
    input  logic                mem_valid,
    input  logic [FLIT_W-1:0]   mem_data,
    output logic                mem_ready,
    output logic                out_valid,
    output logic [FLIT_W-1:0]   out_data,
    output logic [1:0]          out_tag,
    input  logic                out_ready
);
    logic                mode_locked, link_cxl, force_io, hold_q;
    logic [STARVE_W-1:0] starve_cnt;
    proto_tag_e          sel;

    flitmux_mode_gate u_mode (
        .clk(clk), .rst_n(rst_n), .mode_valid(mode_valid), .mode_cxl(mode_cxl),
        .locked(mode_locked), .cxl_en(link_cxl)
    );

    flitmux_starve_ctr #(.STARVE_W(STARVE_W)) u_starve (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid && mode_locked),
        .io_taken(io_ready), .limit(starve_limit),
        .count(starve_cnt), .force_io(force_io)
    );

    flitmux_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .locked(mode_locked), .cxl_en(link_cxl),
        .io_v(io_valid), .cache_v(cache_valid), .mem_v(mem_valid),
        .force_io(force_io), .out_ready(out_ready),
        .sel(sel), .any(out_valid), .hold(hold_q)
    );

    // Steer payload and tag, and hand the ready back to the winner.
    always_comb begin
        out_tag     = sel;
        io_ready    = out_valid && out_ready && sel == TAG_IO;
        cache_ready = out_valid && out_ready && sel == TAG_CACHE;
        mem_ready   = out_valid && out_ready && sel == TAG_MEM;
        case (sel)
            TAG_CACHE: out_data = cache_data;
            TAG_MEM:   out_data = mem_data;
            default:   out_data = io_data;
        endcase
    end
endmodule

// File: rtl/flitmux_checker.sv
// Protocol and policy properties of proto_flit_mux, bound to the top.
module flitmux_checker #(
    parameter int FLIT_W   = 32,
    parameter int STARVE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_locked,
    input logic                link_cxl,
    input logic                hold_q,
    input logic [STARVE_W-1:0] starve_cnt,
    input logic [STARVE_W-1:0] starve_limit,
    input logic                io_valid,
    input logic                cache_valid,
    input logic                mem_valid,
    input logic                io_ready,
    input logic                cache_ready,
    input logic                mem_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [1:0]          out_tag,
    input logic [FLIT_W-1:0]   out_data
);
    assert_idle_before_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_locked |-> !out_valid && !io_ready && !cache_ready && !mem_ready);

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_locked |=> mode_locked && $stable(link_cxl));

    assert_fallback_dormant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_locked && !link_cxl |-> !cache_ready && !mem_ready);

    assert_coherency_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready && link_cxl && (cache_valid || mem_valid) |->
            hold_q || (starve_limit != '0 && starve_cnt >= starve_limit));

    assert_starve_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_locked && !hold_q && io_valid && starve_limit != '0 &&
        starve_cnt >= starve_limit |-> out_valid && out_tag == 2'b00);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_data));

    assert_one_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_ready, cache_ready, mem_ready}) &&
        ((io_ready || cache_ready || mem_ready) -> (out_ready && out_valid)));
endmodule

bind proto_flit_mux flitmux_checker #(.FLIT_W(FLIT_W), .STARVE_W(STARVE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_locked(mode_locked), .link_cxl(link_cxl),
    .hold_q(hold_q), .starve_cnt(starve_cnt), .starve_limit(starve_limit),
    .io_valid(io_valid), .cache_valid(cache_valid), .mem_valid(mem_valid),
    .io_ready(io_ready), .cache_ready(cache_ready), .mem_ready(mem_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data)
);

// File: tb/test_proto_flit_mux.sv
module test_proto_flit_mux;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 32;
    localparam int SW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_valid = 0, mode_cxl = 0, out_ready = 0;
    logic [SW-1:0] lim = '0;
    logic iv = 0, cv = 0, mv = 0;
    logic [FW-1:0] id = '0, cd = '0, md = '0;
    logic io_ready, cache_ready, mem_ready, out_valid;
    logic [FW-1:0] out_data;
    logic [1:0] out_tag;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    // bench model state
    bit m_lock, m_cxl, m_hold, m_pm;
    logic [1:0] m_hsel;
    int m_cnt;
    logic [1:0] e_tag;
    bit e_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    proto_flit_mux #(.FLIT_W(FW), .STARVE_W(SW)) i_proto_flit_mux (
        .clk(clk), .rst_n(rst_n), .mode_valid(mode_valid), .mode_cxl(mode_cxl),
        .starve_limit(lim), .io_valid(iv), .io_data(id), .io_ready(io_ready),
        .cache_valid(cv), .cache_data(cd), .cache_ready(cache_ready),
        .mem_valid(mv), .mem_data(md), .mem_ready(mem_ready),
        .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag),
        .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // Expected selection from the requirements.
    function automatic logic [1:0] exp_sel();
        bit c = m_cxl && cv, m = m_cxl && mv;
        if (m_hold) return m_hsel;
        if (lim != 0 && m_cnt >= lim && iv) return 2'b00;
        if (c && m) return m_pm ? 2'b10 : 2'b01;
        if (c) return 2'b01;
        if (m) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [FW-1:0] exp_data(input logic [1:0] t);
        return t == 2'b01 ? cd : (t == 2'b10 ? md : id);
    endfunction

    // Compare one cycle (inputs already set), then advance one clock.
    task automatic step();
        bit fire_io;
        #1;
        e_valid = m_lock && (m_hold || iv || (m_cxl && (cv || mv)));
        e_tag = exp_sel();
        chk(out_valid == e_valid, "R5", out_valid, e_valid);
        if (e_valid) begin
            chk(out_tag == e_tag, "R9", out_tag, e_tag);
            chk(out_data == exp_data(e_tag), "R9", out_data, exp_data(e_tag));
        end
        chk(io_ready == (e_valid && out_ready && e_tag == 2'b00), "R11", io_ready, 0);
        chk(cache_ready == (e_valid && out_ready && e_tag == 2'b01), "R11", cache_ready, 0);
        chk(mem_ready == (e_valid && out_ready && e_tag == 2'b10), "R11", mem_ready, 0);
        if (m_lock && !m_cxl) chk(!cache_ready && !mem_ready, "R3", {cache_ready, mem_ready}, 0);
        // model update
        fire_io = e_valid && out_ready && e_tag == 2'b00;
        if (!m_lock || !iv || fire_io) m_cnt = 0;
        else if (m_cnt < 255) m_cnt++;
        if (e_valid && out_ready && e_tag == 2'b01) m_pm = 1;
        if (e_valid && out_ready && e_tag == 2'b10) m_pm = 0;
        m_hold = e_valid && !out_ready;
        m_hsel = e_tag;
        if (!m_lock && mode_valid) begin m_lock = 1; m_cxl = mode_cxl; end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_reset(input bit cxl, input logic [SW-1:0] l);
        rst_n = 0; iv = 0; cv = 0; mv = 0; mode_valid = 0; out_ready = 1; lim = l;
        @(posedge clk); @(negedge clk);
        rst_n = 1;
        m_lock = 0; m_cxl = 0; m_hold = 0; m_pm = 0; m_hsel = 0; m_cnt = 0;
        // R1: all sources ready but mode not yet valid
        iv = 1; cv = 1; mv = 1; mode_cxl = cxl;
        #1 chk(!out_valid && !io_ready && !cache_ready && !mem_ready, "R1", out_valid, 0);
        step();
        mode_valid = 1;
        step();
        mode_valid = 0;
        mode_cxl = ~cxl; // R2: later change ignored
    endtask

    // Random traffic: sources hold until accepted.
    task automatic random_run(input int n);
        for (int k = 0; k < n; k++) begin
            out_ready = ($urandom_range(3) != 0);
            if (!iv) begin iv = $urandom_range(1); id = $urandom; end
            if (!cv) begin cv = $urandom_range(1); cd = $urandom; end
            if (!mv) begin mv = $urandom_range(1); md = $urandom; end
            #1;
            begin
                bit a = io_ready, b = cache_ready, c = mem_ready;
                step();
                if (a) iv = 0;
                if (b) cv = 0;
                if (c) mv = 0;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        // ---- full mode, directed ----
        do_reset(1, 8'd2);
        iv = 0; cv = 1; mv = 1; cd = 32'hC0; md = 32'hE0;
        begin
            logic [1:0] first;
            first = out_tag;
            step();
            chk(out_tag != first && out_tag != 2'b00, "R6", out_tag, first ^ 2'b11);
            step();
            chk(out_tag == first, "R6", out_tag, first);
            step();
        end
        // R7: cache always valid, I/O forced after limit waits
        mv = 0; iv = 1; id = 32'hA5;
        step(); step();
        chk(out_tag == 2'b00, "R7", out_tag, 0);
        step();
        chk(out_tag == 2'b01, "R5", out_tag, 1);
        // R10: stall on I/O, cache appears, tag must stay
        cv = 0; out_ready = 0;
        step();
        cv = 1;
        chk(out_tag == 2'b00 && out_valid, "R10", out_tag, 0);
        step();
        chk(out_tag == 2'b00 && out_data == 32'hA5, "R10", out_tag, 0);
        out_ready = 1;
        step();
        random_run(3000);
        // ---- override disabled ----
        do_reset(1, 8'd0);
        iv = 1; cv = 1; mv = 0;
        for (int k = 0; k < 20; k++) begin
            #1 chk(!io_ready, "R8", io_ready, 0);
            step();
        end
        random_run(3000);
        // ---- fallback mode ----
        do_reset(0, 8'd3);
        iv = 1; cv = 1; mv = 1; id = 32'h10;
        #1 chk(io_ready && !cache_ready && !mem_ready, "R3", {io_ready, cache_ready, mem_ready}, 4);
        chk(out_tag == 2'b00, "R4", out_tag, 0);
        chk(!cache_ready, "R2", cache_ready, 0);
        step();
        random_run(3000);
        done = 1;
    end

    initial begin
        wait (done || cyc > 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule